// File: doc/BRIEF.md
# Host Receive Output Stage

This block is the last register on the path that carries words from an on-chip processor out to a host bus. It holds a single 32-bit word pulled from an internal FIFO. It shows that word on the host data bus through a byte-lane format selector, and it raises a request flag while the word is waiting. Neither side can write the register directly: it fills only by popping the FIFO, and it empties only through a host read, a flush or a reset.

A 2-bit format input picks which bytes of the held word reach the bus and where they land. Every format drives all four byte lanes, and the host byte enables are accepted but have no effect. The control side can pulse a synchronous flush that empties the stage. A flush takes priority over a pop in the same cycle. When a host read drains the stage and the FIFO has data, the stage refills in the same cycle, so it can pass one word per clock.

Top module: `host_rx_stage`

## Requirements
- R1: While rst_n is low at a clock edge, the stage is empty after that edge. During reset, rx_req_o is 0, host_data_o is 0 and fifo_pop_o is 0, even when the FIFO is not empty.
- R2: rx_req_o is 1 exactly while the stage holds a word. A held word stays unchanged until a host read or a flush removes it.
- R3: fifo_pop_o is 1 exactly when all of the following hold: the stage is empty or is being read this cycle, fifo_empty_i is 0, flush_i is 0, and reset is not active. The word on fifo_data_i in that cycle becomes the held word at the next edge.
- R4: host_data_o depends on fmt_sel_i and the held word w. Code 0 gives w. Code 1 gives {8'h00, w[23:0]}. Code 2 gives {w[15:0], w[15:0]}. Code 3 gives {w[7:0], w[7:0], w[7:0], w[7:0]}.
- R5: A cycle with flush_i at 1 suppresses any pop in that cycle, and the stage is empty after the edge.
- R6: A host read (host_rd_i at 1) while the stage is full empties it at the edge, unless a pop in the same cycle loads the next word.
- R7: While the stage is empty, host_data_o is 0 for every format, and a host read leaves rx_req_o at 0.
- R8: host_be_i has no effect. host_data_o is the same for every byte-enable value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty_i | input | 1 | FIFO has no word to give |
| fifo_data_i | input | 32 | FIFO head word, valid in the cycle fifo_pop_o is high |
| fifo_pop_o | output | 1 | Take the FIFO head word at this edge |
| flush_i | input | 1 | Synchronous flush of the stage |
| fmt_sel_i | input | 2 | Byte selection and alignment format |
| host_be_i | input | 4 | Host byte enables (ignored) |
| host_rd_i | input | 1 | Host read that drains the stage |
| host_data_o | output | 32 | Formatted word for the host bus |
| rx_req_o | output | 1 | Stage holds a valid word |

## Verification
Two functions can fall in the same cycle: a host read that drains the stage and a FIFO pop that refills it. A flush can also meet a pop. The random phase makes reads, flushes and a non-empty FIFO frequent and independent, so both collisions occur many times. Directed steps also force each one. Each cycle the bench model decides which event wins: flush first, then refill, then drain. The bench judges the result on the pop strobe, the flag and the formatted data in the following cycle.

// File: rtl/host_rx_pkg.sv
// Package: shared widths and format codes for the host receive output stage.
// Assumes a byte-lane bus whose width is a multiple of 16 bits.
package host_rx_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANE_W  = 8;
    localparam int unsigned LANES   = WORD_W / LANE_W;
    localparam int unsigned FMT_W   = 2;

    // Byte selection and alignment formats seen on the host bus.
    typedef enum logic [FMT_W-1:0] {
        FMT_WORD   = 2'd0,   // whole word
        FMT_LOW3   = 2'd1,   // low three bytes, top lane zero
        FMT_HALF2  = 2'd2,   // low half in both halves
        FMT_BYTE4  = 2'd3    // low byte in every lane
    } host_fmt_e;

endpackage

// File: rtl/host_rx_hold.sv
// Module: holding register and valid flag of the output stage.
// Decides when to pop the FIFO (empty or draining, FIFO ready, no flush)
// and captures the FIFO head on that edge. Assumes fifo_data_i is valid
// in the same cycle the pop strobe is high (show-ahead FIFO).
module host_rx_hold #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    input  logic              flush_i,
    input  logic              host_rd_i,
    output logic              pop_o,
    output logic              full_o,
    output logic [DATA_W-1:0] word_o
);

    logic              full_q;
    logic [DATA_W-1:0] word_q;
    logic              room;

    // Purpose: decide whether a FIFO word may enter this cycle.
    always_comb begin
        room  = !full_q || host_rd_i;
        pop_o = rst_n && room && !fifo_empty_i && !flush_i;
    end

    // Purpose: update the valid flag; flush beats fill, fill beats drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (flush_i) begin
            full_q <= 1'b0;
        end else if (pop_o) begin
            full_q <= 1'b1;
        end else if (host_rd_i) begin
            full_q <= 1'b0;
        end
    end

    // Purpose: capture the FIFO head word on a pop; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (pop_o) begin
            word_q <= fifo_data_i;
        end
    end

    assign full_o = full_q;
    assign word_o = word_q;

endmodule

// File: rtl/host_rx_fmt.sv
// Module: byte-lane format selector. Builds each output lane from the held
// word according to the format code, and forces zero when no word is held.
// Assumes an even lane count. Byte enables are deliberately not an input.
module host_rx_fmt
    import host_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic              valid_i,
    input  logic [FMT_W-1:0]  fmt_i,
    output logic [DATA_W-1:0] bus_o
);

    localparam int unsigned NL   = DATA_W / LANE_W;
    localparam int unsigned HALF = NL / 2;

    // One selector per byte lane; the lane index fixes its sources.
    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LANE_W-1:0] own_b;
        logic [LANE_W-1:0] half_b;
        logic [LANE_W-1:0] low_b;
        logic [LANE_W-1:0] lane_d;

        assign own_b  = word_i[g*LANE_W +: LANE_W];
        assign half_b = word_i[(g % HALF)*LANE_W +: LANE_W];
        assign low_b  = word_i[LANE_W-1:0];

        // Purpose: pick this lane's byte for the active format.
        always_comb begin
            unique case (host_fmt_e'(fmt_i))
                FMT_WORD:  lane_d = own_b;
                FMT_LOW3:  lane_d = (g == NL-1) ? '0 : own_b;
                FMT_HALF2: lane_d = half_b;
                FMT_BYTE4: lane_d = low_b;
                default:   lane_d = '0;
            endcase
        end

        assign bus_o[g*LANE_W +: LANE_W] = valid_i ? lane_d : '0;
    end

endmodule

// File: rtl/host_rx_stage.sv
// Module: top of the host receive output stage. Joins the holding register
// to the format selector. Host byte enables are accepted and left unused,
// because every format drives all lanes.
module host_rx_stage
    import host_rx_pkg::*;
#(
    parameter int unsigned DATA_W = WORD_W,
    parameter int unsigned BE_W   = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    input  logic              flush_i,
    input  logic [FMT_W-1:0]  fmt_sel_i,
    input  logic [BE_W-1:0]   host_be_i,
    input  logic              host_rd_i,
    output logic [DATA_W-1:0] host_data_o,
    output logic              rx_req_o
);

    logic              full;
    logic [DATA_W-1:0] word;
    logic              be_unused;

    // Byte enables do not steer any lane.
    assign be_unused = ^host_be_i;

    host_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_empty_i (fifo_empty_i),
        .fifo_data_i  (fifo_data_i),
        .flush_i      (flush_i),
        .host_rd_i    (host_rd_i),
        .pop_o        (fifo_pop_o),
        .full_o       (full),
        .word_o       (word)
    );

    host_rx_fmt #(.DATA_W(DATA_W)) u_fmt (
        .word_i  (word),
        .valid_i (full),
        .fmt_i   (fmt_sel_i),
        .bus_o   (host_data_o)
    );

    assign rx_req_o = full;

endmodule

// File: rtl/host_rx_stage_chk.sv
// Module: assertion checker for the host receive output stage, bound to it.
// Looks only at the top-level ports.
module host_rx_stage_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_empty_i,
    input logic              fifo_pop_o,
    input logic              flush_i,
    input logic              host_rd_i,
    input logic [DATA_W-1:0] host_data_o,
    input logic              rx_req_o
);

    AST_NO_POP_IN_RESET: assert property (@(posedge clk) !rst_n |-> !fifo_pop_o); // R1
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_o && !host_rd_i && !flush_i |=> rx_req_o); // R2
    AST_POP_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> rx_req_o); // R3
    AST_NO_POP_DRY: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty_i |-> !fifo_pop_o); // R3
    AST_FULL_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_o && !host_rd_i |-> !fifo_pop_o); // R3
    AST_FLUSH_BLOCKS_POP: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |-> !fifo_pop_o); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !rx_req_o); // R5
    AST_READ_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_req_o && host_rd_i && !fifo_pop_o |=> !rx_req_o); // R6
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_req_o |-> host_data_o == '0); // R7

endmodule

bind host_rx_stage host_rx_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty_i (fifo_empty_i),
    .fifo_pop_o   (fifo_pop_o),
    .flush_i      (flush_i),
    .host_rd_i    (host_rd_i),
    .host_data_o  (host_data_o),
    .rx_req_o     (rx_req_o)
);

// File: tb/tb_host_rx_stage.sv
// Bench: random and directed stimulus against a cycle model built from the
// requirements. Inputs change at the falling edge and checks sample 1 ns later.
module tb_host_rx_stage;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        fifo_empty_i;
    logic [31:0] fifo_data_i;
    logic        fifo_pop_o;
    logic        flush_i;
    logic [1:0]  fmt_sel_i;
    logic [3:0]  host_be_i;
    logic        host_rd_i;
    logic [31:0] host_data_o;
    logic        rx_req_o;

    int checks = 0;
    int errors = 0;
    bit wd_hit = 1'b0;

    bit          m_full = 1'b0;
    logic [31:0] m_word = '0;

    always #5 clk = ~clk;

    host_rx_stage dut (
        .clk(clk), .rst_n(rst_n), .fifo_empty_i(fifo_empty_i),
        .fifo_data_i(fifo_data_i), .fifo_pop_o(fifo_pop_o), .flush_i(flush_i),
        .fmt_sel_i(fmt_sel_i), .host_be_i(host_be_i), .host_rd_i(host_rd_i),
        .host_data_o(host_data_o), .rx_req_o(rx_req_o)
    );

    function automatic logic [31:0] fmt_exp(logic [31:0] w, logic [1:0] f, bit v);
        if (!v) return 32'h0;
        case (f)
            2'd0:    return w;
            2'd1:    return {8'h00, w[23:0]};
            2'd2:    return {w[15:0], w[15:0]};
            default: return {4{w[7:0]}};
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive, check the combinational outputs, advance the model.
    task automatic step(bit emp, logic [31:0] d, bit fl, logic [1:0] f,
                        logic [3:0] be, bit rd);
        bit pop_e;
        fifo_empty_i = emp; fifo_data_i = d; flush_i = fl;
        fmt_sel_i = f; host_be_i = be; host_rd_i = rd;
        #1;
        pop_e = (!m_full || rd) && !emp && !fl;
        chk(fl ? "R5 pop" : "R3 pop", {31'd0, fifo_pop_o}, {31'd0, pop_e});
        chk("R2 flag", {31'd0, rx_req_o}, {31'd0, m_full});
        chk(m_full ? "R4 data" : "R7 data", host_data_o, fmt_exp(m_word, f, m_full));
        @(posedge clk);
        if (fl) m_full = 1'b0;
        else if (pop_e) begin m_full = 1'b1; m_word = d; end
        else if (rd) m_full = 1'b0;
        @(negedge clk);
    endtask

    task automatic run();
        logic [31:0] a, b;
        void'($urandom(32'h5eed_0042));
        // R1: reset state with a ready FIFO
        rst_n = 1'b0; fifo_empty_i = 1'b0; fifo_data_i = 32'hDEAD_BEEF;
        flush_i = 0; fmt_sel_i = 0; host_be_i = 4'hF; host_rd_i = 0;
        repeat (3) @(negedge clk);
        chk("R1 pop in reset", {31'd0, fifo_pop_o}, 32'd0);
        chk("R1 flag in reset", {31'd0, rx_req_o}, 32'd0);
        chk("R1 data in reset", host_data_o, 32'd0);
        rst_n = 1'b1;
        // R7: read while empty for all formats
        for (int f = 0; f < 4; f++) step(1, 32'h1234_5678, 0, 2'(f), 4'hF, 1);
        // R4 and R8: load a word and hold it through every format and byte enable
        step(0, 32'hA1B2_C3D4, 0, 0, 4'h0, 0);
        for (int f = 0; f < 4; f++) begin
            fmt_sel_i = 2'(f); fifo_empty_i = 1;
            host_be_i = 4'h0; #1; a = host_data_o;
            host_be_i = 4'h5; #1; b = host_data_o;
            chk("R8 be=0 vs be=5", a, b);
            host_be_i = 4'hF; #1;
            chk("R8 be=F", host_data_o, a);
            step(1, 32'h0, 0, 2'(f), 4'hA, 0);
        end
        chk("R4 fmt3 value", fmt_exp(32'hA1B2_C3D4, 3, 1), 32'hD4D4_D4D4);
        // R6: read and refill in one cycle, then read to empty
        step(0, 32'h0BAD_F00D, 0, 0, 4'hF, 1);
        step(1, 32'h0, 0, 1, 4'hF, 1);
        step(1, 32'h0, 0, 0, 4'hF, 0);
        // R5: flush meets a pop, and flush of a full stage
        step(0, 32'h5555_AAAA, 1, 0, 4'hF, 0);
        step(0, 32'h7777_1111, 0, 0, 4'hF, 0);
        step(0, 32'h8888_2222, 1, 2, 4'hF, 1);
        step(1, 32'h0, 0, 0, 4'hF, 0);
        // Random phase
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) == 0, $urandom, ($urandom % 8) == 0,
                 2'($urandom), 4'($urandom), ($urandom % 3) == 0);
        // R1: reset mid-run empties a full stage
        step(0, 32'hCAFE_0001, 0, 0, 4'hF, 0);
        rst_n = 1'b0; @(posedge clk); @(negedge clk);
        chk("R1 flag after reset", {31'd0, rx_req_o}, 32'd0);
        chk("R1 data after reset", host_data_o, 32'd0);
        rst_n = 1'b1; m_full = 1'b0;
        step(1, 32'h0, 0, 0, 4'hF, 0);
    endtask

    initial begin
        @(negedge clk);
        fork
            run();
            begin repeat (100000) @(posedge clk); wd_hit = 1'b1; end
        join_any
        if (wd_hit) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=expired expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule